// File: doc/BRIEF.md
# Timer Compare Waveform Unit

This block is an 8-bit timer/counter with one compare channel that shapes a single waveform bit and can put it on an output pin. A small write port sets two things: a control byte, which holds a three-bit counting-mode code and a two-bit output-action code, and the compare value. On every enabled tick the counter advances. The compare logic then looks at the count as it was before that tick. A match, or the wrap back to zero, sets, clears or toggles the waveform register, depending on the two codes.

There are three counting styles: free-running, clear-on-match, and fast PWM with a top of either 0xFF or the compare value. The meaning of the output-action code changes with the counting style. In fast PWM the compare value is double-buffered. The pin mux picks between the waveform and the general-purpose port value, using the action code, the counting style and the pin's direction bit.

Top module: `tmr_wave_unit`

## Requirements
- R1: After a synchronous reset the count is 0 and the waveform level is 0. Both control codes are 0, which means free-running with the pin disconnected, so the pin carries `port_val`.
- R2: A write with `wr_addr`=0 loads the control byte. Bits [2:0] hold the mode code and bits [5:4] hold the action code. Codes 000, 001, 100, 101 and 110 all mean free-running: the count rises by one per cycle with `tick` high, wraps from 0xFF to 0x00, and holds while `tick` is low.
- R3: Mode 010 is clear-on-match. On a tick where the count equals the compare value, the next count is 0.
- R4: Mode 011 is fast PWM with top 0xFF. Mode 111 is fast PWM with top equal to the compare value. On a tick at top, the count returns to 0 (the wrap event).
- R5: In the non-PWM modes a compare match acts on the waveform as follows: action 01 toggles it, 10 clears it, 11 sets it, and 00 does nothing.
- R6: In fast PWM, action 10 clears on a match and sets on the wrap, which gives a non-inverted waveform. Action 11 sets on a match and clears on the wrap, which gives an inverted waveform.
- R7: In fast PWM, action 01 toggles on a match only when mode bit 2 is 1. When mode bit 2 is 0, the waveform is not changed and the pin is disconnected.
- R8: In fast PWM, when the compare value equals top and action bit 1 is set, the match action is skipped and only the wrap action applies.
- R9: A write with `wr_addr`=1 loads the compare value. It takes effect at once in the non-PWM modes. In fast PWM it waits in a buffer and moves into use on the tick at top.
- R10: `wave_pin` equals `wave_level` only when the action code is nonzero, the pin is not disconnected by R7, and `pin_dir` is 1. Otherwise `wave_pin` equals `port_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control byte, 1 = compare value |
| wr_data | input | 8 | Write data |
| tick | input | 1 | Counter advance enable |
| pin_dir | input | 1 | Pin direction, 1 = output |
| port_val | input | 1 | General-purpose value for the pin |
| count | output | 8 | Current counter value |
| wave_level | output | 1 | Waveform register |
| wave_pin | output | 1 | Muxed pin value |

## Verification
The bench sets up a compare value equal to top in fast PWM. A design that does not skip the match clears a non-inverted waveform on the very tick that should set it. The bench moves the compare value in the middle of a PWM period. A design without the buffer misses the match at the old value, and one that buffers in the non-PWM modes misses the match at the new value. Fast PWM with action 01 is run with mode bit 2 both clear and set. This catches designs that toggle, or drive the pin, when they should leave it alone. Further cases cover a clear-on-match restart, a 0xFF wrap, and the reserved mode codes, which a sloppy decoder would treat as clear-on-match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Write-port address map
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_CMP  = 1'b1;

    // Control byte field positions
    localparam int MODE_LSB = 0;
    localparam int ACT_LSB  = 4;

    typedef enum logic [1:0] {
        MD_FREE     = 2'd0,
        MD_CTC      = 2'd1,
        MD_PWM_FULL = 2'd2,
        MD_PWM_VAR  = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        WA_NONE   = 2'd0,
        WA_TOGGLE = 2'd1,
        WA_CLEAR  = 2'd2,
        WA_SET    = 2'd3
    } wave_act_e;

    typedef struct packed {
        logic [1:0] act;   // output-action code
        logic [2:0] mode;  // counting-mode code
    } ctrl_t;

    function automatic cnt_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'b010:  return MD_CTC;
            3'b011:  return MD_PWM_FULL;
            3'b111:  return MD_PWM_VAR;
            default: return MD_FREE;
        endcase
    endfunction

    function automatic logic is_pwm(input cnt_mode_e m);
        return (m == MD_PWM_FULL) || (m == MD_PWM_VAR);
    endfunction

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         at_top,
    output ctrl_t        ctrl,
    output cnt_mode_e    mode,
    output logic [W-1:0] cmp_act
);
    logic [W-1:0] cmp_buf;
    logic         pwm;

    assign mode = decode_mode(ctrl.mode);
    assign pwm  = is_pwm(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            ctrl.mode <= wr_data[MODE_LSB +: 3];
            ctrl.act  <= wr_data[ACT_LSB +: 2];
        end
    end

    // Compare value: buffered in PWM, direct otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_buf <= '0;
            cmp_act <= '0;
        end else begin
            if (wr_en && wr_addr == ADDR_CMP) begin
                cmp_buf <= wr_data;
                if (!pwm)
                    cmp_act <= wr_data;
            end
            if (pwm && tick && at_top)
                cmp_act <= cmp_buf;
        end
    end

    // R9: in PWM the live compare value only moves at top
    assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (pwm && !(tick && at_top)) |=> $stable(cmp_act));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  cnt_mode_e    mode,
    input  logic [W-1:0] cmp_act,
    output logic [W-1:0] count,
    output logic         at_top,
    output logic         match
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic [W-1:0] top_val;
    logic         restart;

    assign top_val = (mode == MD_PWM_VAR) ? cmp_act : FULL;
    assign at_top  = (count == top_val);
    assign match   = (count == cmp_act);
    assign restart = ((mode == MD_CTC) && match) || (is_pwm(mode) && at_top);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (tick)
            count <= restart ? '0 : count + 1'b1;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MD_FREE && count == FULL) |=> count == '0);

    assert_ctc_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MD_CTC && count == cmp_act) |=> count == '0);

    assert_pwm_top_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && mode == MD_PWM_VAR && count == cmp_act) |=> count == '0);

endmodule

// File: rtl/tmr_wave_out.sv
module tmr_wave_out
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  cnt_mode_e  mode,
    input  ctrl_t      ctrl,
    input  logic       match,
    input  logic       at_top,
    input  logic       pin_dir,
    input  logic       port_val,
    output logic       wave_q,
    output logic       pin
);
    logic      pwm;
    logic      sel_bit2;
    logic      connected;
    wave_act_e act;

    assign pwm      = is_pwm(mode);
    assign sel_bit2 = ctrl.mode[2];

    always_comb begin
        act = WA_NONE;
        if (tick) begin
            if (!pwm) begin
                if (match)
                    act = wave_act_e'(ctrl.act);
            end else begin
                // compare event, skipped at top when action bit 1 is set
                if (match && !(at_top && ctrl.act[1])) begin
                    case (ctrl.act)
                        2'b01:   act = sel_bit2 ? WA_TOGGLE : WA_NONE;
                        2'b10:   act = WA_CLEAR;
                        2'b11:   act = WA_SET;
                        default: act = WA_NONE;
                    endcase
                end
                // wrap event
                if (at_top && ctrl.act[1])
                    act = ctrl.act[0] ? WA_CLEAR : WA_SET;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            wave_q <= 1'b0;
        else begin
            case (act)
                WA_TOGGLE: wave_q <= ~wave_q;
                WA_CLEAR:  wave_q <= 1'b0;
                WA_SET:    wave_q <= 1'b1;
                default:   wave_q <= wave_q;
            endcase
        end
    end

    assign connected = (ctrl.act != 2'b00) && !(pwm && ctrl.act == 2'b01 && !sel_bit2);
    assign pin       = (connected && pin_dir) ? wave_q : port_val;

    assert_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(wave_q));

    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !pwm && match && ctrl.act == 2'b11) |=> wave_q);

    assert_top_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && pwm && match && at_top && ctrl.act[1]) |=> (wave_q == ~$past(ctrl.act[0])));

    assert_no_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (pwm && ctrl.act == 2'b01 && !sel_bit2) |=> $stable(wave_q));

endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
    import tmr_pkg::*;
#(
    parameter int W = 8   // must be at least 6 to hold the control fields
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         pin_dir,
    input  logic         port_val,
    output logic [W-1:0] count,
    output logic         wave_level,
    output logic         wave_pin
);
    ctrl_t        ctrl;
    cnt_mode_e    mode;
    logic [W-1:0] cmp_act;
    logic         at_top;
    logic         match;

    tmr_ctrl_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .at_top  (at_top),
        .ctrl    (ctrl),
        .mode    (mode),
        .cmp_act (cmp_act)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .mode    (mode),
        .cmp_act (cmp_act),
        .count   (count),
        .at_top  (at_top),
        .match   (match)
    );

    tmr_wave_out u_wave (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode     (mode),
        .ctrl     (ctrl),
        .match    (match),
        .at_top   (at_top),
        .pin_dir  (pin_dir),
        .port_val (port_val),
        .wave_q   (wave_level),
        .pin      (wave_pin)
    );

    // R10: with the direction bit clear the pin follows the port value
    assert_pin_port_R10: assert property (@(posedge clk) disable iff (rst)
        !pin_dir |-> wave_pin == port_val);

endmodule

// File: tb/sim_tmr_wave_unit.sv
module sim_tmr_wave_unit;

    typedef struct packed {
        logic [2:0]  mode;
        logic [1:0]  act;
        logic [7:0]  cmp;
        logic        dir;
        logic        port;
        logic [15:0] ticks;
        logic [7:0]  exp_cnt;
        logic        exp_lvl;
        logic        exp_pin;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 2'b01, 8'd3, 1'b1, 1'b0, 16'd4,   8'd4, 1'b1, 1'b1}, // R5 toggle
        '{3'b000, 2'b11, 8'd5, 1'b1, 1'b0, 16'd6,   8'd6, 1'b1, 1'b1}, // R5 set
        '{3'b010, 2'b01, 8'd4, 1'b1, 1'b0, 16'd7,   8'd2, 1'b1, 1'b1}, // R3 restart
        '{3'b011, 2'b10, 8'd3, 1'b1, 1'b0, 16'd258, 8'd2, 1'b1, 1'b1}, // R6 R4 set at wrap
        '{3'b011, 2'b10, 8'd3, 1'b1, 1'b0, 16'd260, 8'd4, 1'b0, 1'b0}, // R6 clear on match
        '{3'b011, 2'b11, 8'd3, 1'b1, 1'b0, 16'd4,   8'd4, 1'b1, 1'b1}, // R6 inverted set
        '{3'b011, 2'b11, 8'd3, 1'b1, 1'b0, 16'd256, 8'd0, 1'b0, 1'b0}, // R6 R4 inverted clear
        '{3'b111, 2'b10, 8'd5, 1'b1, 1'b0, 16'd6,   8'd0, 1'b1, 1'b1}, // R8 R4 skip match
        '{3'b111, 2'b10, 8'd5, 1'b1, 1'b0, 16'd12,  8'd0, 1'b1, 1'b1}, // R8 second period
        '{3'b111, 2'b01, 8'd5, 1'b1, 1'b0, 16'd6,   8'd0, 1'b1, 1'b1}, // R7 toggle enabled
        '{3'b011, 2'b01, 8'd3, 1'b1, 1'b0, 16'd4,   8'd4, 1'b0, 1'b0}, // R7 disconnected
        '{3'b000, 2'b01, 8'd0, 1'b0, 1'b0, 16'd1,   8'd1, 1'b1, 1'b0}, // R10 direction in
        '{3'b000, 2'b00, 8'd0, 1'b1, 1'b1, 16'd1,   8'd1, 1'b0, 1'b1}, // R10 action off
        '{3'b000, 2'b00, 8'd0, 1'b1, 1'b0, 16'd257, 8'd1, 1'b0, 1'b0}, // R2 wrap
        '{3'b001, 2'b01, 8'd3, 1'b1, 1'b0, 16'd6,   8'd6, 1'b1, 1'b1}  // R2 reserved code
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick = 1'b0;
    logic       pin_dir = 1'b0;
    logic       port_val = 1'b0;
    logic [7:0] count;
    logic       wave_level;
    logic       wave_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tmr_wave_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tick       (tick),
        .pin_dir    (pin_dir),
        .port_val   (port_val),
        .count      (count),
        .wave_level (wave_level),
        .wave_pin   (wave_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0;
        tick = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick = 1'b0;
        end
    endtask

    function automatic logic [7:0] ctl(input logic [2:0] m, input logic [1:0] a);
        return {2'b00, a, 1'b0, m};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        #1;
        // R1: reset state
        pin_dir = 1'b1;
        port_val = 1'b1;
        do_reset();
        check("R1 count", count, 0);
        check("R1 level", wave_level, 0);
        check("R1 pin", wave_pin, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(1'b1, VECS[i].cmp);
            wr(1'b0, ctl(VECS[i].mode, VECS[i].act));
            pin_dir = VECS[i].dir;
            port_val = VECS[i].port;
            run(int'(VECS[i].ticks));
            check($sformatf("vec%0d count", i), count, VECS[i].exp_cnt);
            check($sformatf("vec%0d level", i), wave_level, VECS[i].exp_lvl);
            check($sformatf("vec%0d pin", i), wave_pin, VECS[i].exp_pin);
        end

        // R2: tick low holds the count
        do_reset();
        run(3);
        repeat (5) @(posedge clk);
        #1 check("R2 hold", count, 3);

        // R9: compare write in PWM waits for top
        do_reset();
        pin_dir = 1'b1;
        port_val = 1'b0;
        wr(1'b1, 8'd3);
        wr(1'b0, ctl(3'b011, 2'b10));
        run(256);
        check("R9 start", wave_pin, 1);
        wr(1'b1, 8'd10);
        run(4);
        check("R9 old value used", wave_pin, 0);
        run(252);
        check("R9 wrap count", count, 0);
        check("R9 wrap set", wave_pin, 1);
        run(4);
        check("R9 old gone", wave_pin, 1);
        run(7);
        check("R9 new value", wave_pin, 0);
        check("R9 count", count, 11);

        // R9: non-PWM write is immediate
        do_reset();
        wr(1'b1, 8'd200);
        wr(1'b0, ctl(3'b000, 2'b11));
        run(2);
        wr(1'b1, 8'd3);
        run(2);
        check("R9 immediate", wave_pin, 1);

        // R5: clear on match in free-running
        do_reset();
        wr(1'b1, 8'd2);
        wr(1'b0, ctl(3'b000, 2'b11));
        run(3);
        check("R5 set first", wave_pin, 1);
        wr(1'b0, ctl(3'b000, 2'b10));
        run(256);
        check("R5 clear", wave_pin, 0);
        check("R5 count", count, 3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule